// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of a small direct-mapped, write-back cache in a bus-based multiprocessor. Each line carries a tag and one of four states: invalid, shared, exclusive-clean or modified. Processor reads and writes are served from this state table. A request goes onto the shared bus only when the state requires it: a read fetch, an exclusive fetch, or a writeback of a dirty victim.

A snoop port watches the read and exclusive-read requests of the other caches. When this cache holds the block it drives a wired shared line. When it holds the dirty copy it raises a flush strobe. Its own copy is then demoted or dropped.

The data arrays, memory, the arbitration between caches and the data-bus timing are outside the block. A request address is a block address. Its low `IDX_W` bits pick the line and the remaining bits form the tag.

Top module: `mesiSnoopCtrl`

## Requirements
- R1: After reset every line is invalid: `cpuReady` and `busReq` are low, and a snooped read of any address leaves `sharedOut` and `flushOut` low.
- R2: A processor read that misses issues a bus read (`busCmd` = 2'b01) at the request address. When the transaction completes, the line becomes exclusive-clean if `sharedIn` was low in that cycle and shared if it was high.
- R3: A processor write to an exclusive-clean line completes with no bus request and makes the line modified.
- R4: A processor write that misses, or that hits a shared line, issues a bus exclusive read (`busCmd` = 2'b10) at the request address and leaves the line modified.
- R5: Reads that hit a shared, exclusive-clean or modified line, and writes that hit a modified line, make no bus request. `cpuReady` pulses for one cycle, two cycles after the request is accepted.
- R6: A snooped read (`snoopCmd` = 2'b01) of a block held valid raises `sharedOut` in the same cycle. If the line is modified, `flushOut` is also raised. Modified and exclusive-clean lines become shared.
- R7: A snooped exclusive read (`snoopCmd` = 2'b10) of a block held valid makes the line invalid and raises `flushOut` in the same cycle if the line was modified. `sharedOut` stays low.
- R8: A miss whose victim line is modified first issues a writeback (`busCmd` = 2'b11) at the victim's block address, then the fetch. A clean or invalid victim is replaced with no writeback.
- R9: `busReq` is held with a stable command and address until a cycle with both `busGrant` and `busDone` high. `cpuReady` is never high while `busReq` is high.
- R10: A snoop whose tag differs from the line's tag, or whose command is neither 2'b01 nor 2'b10, changes no state and raises neither `sharedOut` nor `flushOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request, held until `cpuReady` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Block address of the request |
| cpuReady | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Bus transaction request |
| busCmd | output | 2 | 01 read, 10 exclusive read, 11 writeback |
| busAddr | output | ADDR_W | Block address of the bus transaction |
| busGrant | input | 1 | Bus granted to this cache |
| busDone | input | 1 | Transaction completes in a granted cycle |
| sharedIn | input | 1 | Wired shared line, sampled when a read completes |
| snoopValid | input | 1 | A foreign transaction is on the bus |
| snoopCmd | input | 2 | Command of the snooped transaction |
| snoopAddr | input | ADDR_W | Block address of the snooped transaction |
| sharedOut | output | 1 | This cache holds the snooped block (reads only) |
| flushOut | output | 1 | This cache must supply dirty data |

## Verification
The assertions assume that snoops never carry this cache's own transactions. They also assume that snoops arrive only while no processor request is pending, so the snoop and controller paths never update the same line in one cycle. The bench keeps to this by issuing snoops only between processor operations. The processor request is held stable until `cpuReady`, and `busDone` is raised only together with `busGrant`. A reference model of the tag and state of every line predicts the bus command sequence, the addresses, the hit latency and the snoop outputs. The stimulus is a long pseudo-random mix over all lines and three colliding tags, after a sweep of every address following reset.

// File: rtl/mesiCtrlPkg.sv
package mesiCtrlPkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_READX = 2'd2,
    BC_WBACK = 2'd3
  } busCmd_t;

  typedef struct packed {
    logic       latchReq;
    logic       setMod;
    logic       dropLine;
    logic       fillLine;
    lineState_t fillState;
    logic       selWback;
  } ctrlStrobe_t;

endpackage

// File: rtl/mesiTagPath.sv
module mesiTagPath
  import mesiCtrlPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  ctrlStrobe_t       strb,
  input  logic              snoopValid,
  input  logic [1:0]        snoopCmd,
  input  logic [ADDR_W-1:0] snoopAddr,
  output lineState_t        reqState,
  output logic              victimDirty,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              sharedOut,
  output logic              flushOut
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0]  tagArr [LINES];
  lineState_t        stArr  [LINES];
  logic [ADDR_W-1:0] reqAddrQ;
  logic              reqWriteQ;

  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  logic             reqTagMatch;

  assign reqIdx      = reqAddrQ[IDX_W-1:0];
  assign reqTag      = reqAddrQ[ADDR_W-1:IDX_W];
  assign reqTagMatch = (tagArr[reqIdx] == reqTag);
  assign reqState    = reqTagMatch ? stArr[reqIdx] : LS_INV;
  assign victimDirty = !reqTagMatch && (stArr[reqIdx] == LS_MOD);
  assign reqWrite    = reqWriteQ;
  assign busAddr     = strb.selWback ? {tagArr[reqIdx], reqIdx} : reqAddrQ;

  // Snoop lookup, combinational so the shared line is valid in the snoop cycle
  logic [IDX_W-1:0] snpIdx;
  logic [TAG_W-1:0] snpTag;
  lineState_t       snpState;
  logic             snpRead;
  logic             snpReadX;
  logic             snpHit;

  assign snpIdx    = snoopAddr[IDX_W-1:0];
  assign snpTag    = snoopAddr[ADDR_W-1:IDX_W];
  assign snpState  = stArr[snpIdx];
  assign snpRead   = snoopValid && (snoopCmd == BC_READ);
  assign snpReadX  = snoopValid && (snoopCmd == BC_READX);
  assign snpHit    = (snpRead || snpReadX) && (snpState != LS_INV) &&
                     (tagArr[snpIdx] == snpTag);
  assign sharedOut = snpHit && snpRead;
  assign flushOut  = snpHit && (snpState == LS_MOD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqWriteQ <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        tagArr[i] <= '0;
        stArr[i]  <= LS_INV;
      end
    end else begin
      if (strb.latchReq) begin
        reqAddrQ  <= cpuAddr;
        reqWriteQ <= cpuWrite;
      end
      for (int i = 0; i < LINES; i++) begin
        if (strb.fillLine && reqIdx == IDX_W'(i)) begin
          tagArr[i] <= reqTag;
          stArr[i]  <= strb.fillState;
        end else if (strb.dropLine && reqIdx == IDX_W'(i)) begin
          stArr[i] <= LS_INV;
        end else if (strb.setMod && reqIdx == IDX_W'(i)) begin
          stArr[i] <= LS_MOD;
        end else if (snpHit && snpIdx == IDX_W'(i)) begin
          if (snpReadX) begin
            stArr[i] <= LS_INV;
          end else if (snpState == LS_MOD || snpState == LS_EXC) begin
            stArr[i] <= LS_SHR;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mesiCtrlFsm.sv
module mesiCtrlFsm
  import mesiCtrlPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  lineState_t  reqState,
  input  logic        victimDirty,
  input  logic        reqWrite,
  input  logic        busGrant,
  input  logic        busDone,
  input  logic        sharedIn,
  output ctrlStrobe_t strb,
  output logic        cpuReady,
  output logic        busReq,
  output logic [1:0]  busCmd
);

  typedef enum logic [2:0] {
    F_IDLE, F_CHECK, F_WBACK, F_FETCH, F_RESP
  } fsm_t;

  fsm_t curQ, nxt;
  logic busFinish;

  assign busFinish = busGrant && busDone;

  always_comb begin
    strb = '0;
    nxt  = curQ;
    case (curQ)
      F_IDLE: begin
        if (cpuValid) begin
          strb.latchReq = 1'b1;
          nxt = F_CHECK;
        end
      end
      F_CHECK: begin
        if (reqState != LS_INV && (!reqWrite || reqState != LS_SHR)) begin
          strb.setMod = reqWrite;
          nxt = F_RESP;
        end else if (reqState == LS_SHR || !victimDirty) begin
          nxt = F_FETCH;
        end else begin
          nxt = F_WBACK;
        end
      end
      F_WBACK: begin
        strb.selWback = 1'b1;
        if (busFinish) begin
          strb.dropLine = 1'b1;
          nxt = F_FETCH;
        end
      end
      F_FETCH: begin
        if (busFinish) begin
          strb.fillLine  = 1'b1;
          strb.fillState = reqWrite ? LS_MOD : (sharedIn ? LS_SHR : LS_EXC);
          nxt = F_RESP;
        end
      end
      default: nxt = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curQ <= F_IDLE;
    else       curQ <= nxt;
  end

  assign cpuReady = (curQ == F_RESP);
  assign busReq   = (curQ == F_WBACK) || (curQ == F_FETCH);

  always_comb begin
    case (curQ)
      F_WBACK: busCmd = BC_WBACK;
      F_FETCH: busCmd = reqWrite ? BC_READX : BC_READ;
      default: busCmd = BC_NONE;
    endcase
  end

endmodule

// File: rtl/mesiSnoopCtrl.sv
module mesiSnoopCtrl
  import mesiCtrlPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuReady,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGrant,
  input  logic              busDone,
  input  logic              sharedIn,
  input  logic              snoopValid,
  input  logic [1:0]        snoopCmd,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              sharedOut,
  output logic              flushOut
);

  ctrlStrobe_t strb;
  lineState_t  reqState;
  logic        victimDirty;
  logic        reqWrite;

  mesiTagPath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_path (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .strb(strb), .snoopValid(snoopValid), .snoopCmd(snoopCmd),
    .snoopAddr(snoopAddr), .reqState(reqState), .victimDirty(victimDirty),
    .reqWrite(reqWrite), .busAddr(busAddr), .sharedOut(sharedOut),
    .flushOut(flushOut)
  );

  mesiCtrlFsm u_fsm (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .reqState(reqState),
    .victimDirty(victimDirty), .reqWrite(reqWrite), .busGrant(busGrant),
    .busDone(busDone), .sharedIn(sharedIn), .strb(strb),
    .cpuReady(cpuReady), .busReq(busReq), .busCmd(busCmd)
  );

endmodule

// File: rtl/mesiSnoopCtrlChk.sv
module mesiSnoopCtrlChk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              busReq,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busGrant,
  input logic              busDone,
  input logic              snoopValid,
  input logic [1:0]        snoopCmd,
  input logic              sharedOut,
  input logic              flushOut
);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !(busGrant && busDone) |=> busReq && $stable(busCmd) && $stable(busAddr));

  a_r9_cmd_present: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busCmd != 2'b00);

  a_r9_no_ready_in_bus: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !cpuReady);

  a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  a_r6_shared_on_read: assert property (@(posedge clk) disable iff (!rstN)
    sharedOut |-> snoopValid && snoopCmd == 2'b01);

  a_r7_flush_on_snoop: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> snoopValid && (snoopCmd == 2'b01 || snoopCmd == 2'b10));

  a_r8_fetch_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busGrant && busDone && busCmd == 2'b11 |=>
      busReq && (busCmd == 2'b01 || busCmd == 2'b10));

endmodule

bind mesiSnoopCtrl mesiSnoopCtrlChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .busReq(busReq),
  .busCmd(busCmd), .busAddr(busAddr), .busGrant(busGrant), .busDone(busDone),
  .snoopValid(snoopValid), .snoopCmd(snoopCmd), .sharedOut(sharedOut),
  .flushOut(flushOut)
);

// File: tb/mesiSnoopCtrl_tb.sv
`timescale 1ns/1ps
module mesiSnoopCtrl_tb;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic          cpuReady, busReq;
  logic [1:0]    busCmd;
  logic [AW-1:0] busAddr;
  logic          busGrant = 1'b0, busDone = 1'b0, sharedIn = 1'b0;
  logic          snoopValid = 1'b0;
  logic [1:0]    snoopCmd = 2'b00;
  logic [AW-1:0] snoopAddr = '0;
  logic          sharedOut, flushOut;

  int tests = 0;
  int fails = 0;

  // model: state 0 invalid, 1 shared, 2 exclusive-clean, 3 modified
  int mSt [4];
  int mTag [4];

  always #2 clk = ~clk;

  mesiSnoopCtrl u_dut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuReady(cpuReady), .busReq(busReq), .busCmd(busCmd),
    .busAddr(busAddr), .busGrant(busGrant), .busDone(busDone),
    .sharedIn(sharedIn), .snoopValid(snoopValid), .snoopCmd(snoopCmd),
    .snoopAddr(snoopAddr), .sharedOut(sharedOut), .flushOut(flushOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic cpuOp(input bit wr, input logic [AW-1:0] a, input bit shr,
                       output int nb, output logic [3:0] cmds,
                       output logic [15:0] addrs, output int lat);
    bit seen = 0;
    bit justCleared;
    logic [1:0] recCmd = 2'b00;
    logic [AW-1:0] recAddr = '0;
    nb = 0; cmds = '0; addrs = '0; lat = -1;
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a;
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      justCleared = 0;
      if (busGrant) begin
        busGrant = 1'b0; busDone = 1'b0; sharedIn = 1'b0; justCleared = 1;
      end
      if (cpuReady) begin
        check("R9", "ready while bus requested", {31'd0, busReq}, 32'd0);
        cpuValid = 1'b0;
        lat = cyc;
        break;
      end
      if (busReq && !justCleared) begin
        if (!seen) begin
          seen = 1; nb++;
          recCmd = busCmd; recAddr = busAddr;
          cmds  = {cmds[1:0], busCmd};
          addrs = {addrs[7:0], busAddr};
        end else begin
          check("R9", "request held stable", {22'd0, busCmd, busAddr},
                {22'd0, recCmd, recAddr});
          busGrant = 1'b1; busDone = 1'b1; sharedIn = shr; seen = 0;
        end
      end
    end
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a,
                       output logic sh, output logic fl);
    @(negedge clk);
    snoopValid = 1'b1; snoopCmd = cmd; snoopAddr = a;
    #1;
    sh = sharedOut; fl = flushOut;
    @(negedge clk);
    snoopValid = 1'b0; snoopCmd = 2'b00;
  endtask

  task automatic modelCpu(input bit wr, input logic [AW-1:0] a, input bit shr);
    int idx = int'(a[1:0]);
    int tg  = int'(a[7:2]);
    bit hit = (mSt[idx] != 0) && (mTag[idx] == tg);
    int expNb = 0, expLat = -1;
    logic [3:0] expCmds = '0;
    logic [15:0] expAddrs = '0;
    int nb, lat;
    logic [3:0] cmds;
    logic [15:0] addrs;
    string req;
    if (hit && (!wr || mSt[idx] >= 2)) begin
      req = (wr && mSt[idx] == 2) ? "R3" : "R5";
      expLat = 1;
      if (wr) mSt[idx] = 3;
    end else if (hit) begin
      req = "R4";
      expNb = 1; expCmds = 4'b0010; expAddrs = {8'd0, a};
      mSt[idx] = 3;
    end else begin
      req = (mSt[idx] != 0) ? "R8" : (wr ? "R4" : "R2");
      if (mSt[idx] == 3) begin
        expNb = 1; expCmds = 4'b0011;
        expAddrs = {8'd0, 6'(mTag[idx]), 2'(idx)};
      end
      expNb++;
      expCmds  = {expCmds[1:0], wr ? 2'b10 : 2'b01};
      expAddrs = {expAddrs[7:0], a};
      mTag[idx] = tg;
      mSt[idx]  = wr ? 3 : (shr ? 1 : 2);
    end
    cpuOp(wr, a, shr, nb, cmds, addrs, lat);
    check(req, "bus transaction count", nb, expNb);
    check(req, "bus command sequence", {28'd0, cmds}, {28'd0, expCmds});
    check(req, "bus address sequence", {16'd0, addrs}, {16'd0, expAddrs});
    if (expLat >= 0) check("R5", "hit response latency", lat, expLat);
    else check("R9", "response after bus completion", {31'd0, lat > 0}, 32'd1);
  endtask

  task automatic modelSnoop(input logic [1:0] cmd, input logic [AW-1:0] a);
    int idx = int'(a[1:0]);
    bit act = (cmd == 2'b01) || (cmd == 2'b10);
    bit hit = act && (mSt[idx] != 0) && (mTag[idx] == int'(a[7:2]));
    logic sh, fl;
    string req;
    req = !hit ? "R10" : (cmd == 2'b01 ? "R6" : "R7");
    snoop(cmd, a, sh, fl);
    check(req, "sharedOut", {31'd0, sh}, {31'd0, hit && cmd == 2'b01});
    check(req, "flushOut", {31'd0, fl}, {31'd0, hit && mSt[idx] == 3});
    if (hit) begin
      if (cmd == 2'b10) mSt[idx] = 0;
      else if (mSt[idx] >= 2) mSt[idx] = 1;
    end
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    tests++; fails++;
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    logic sh, fl;
    for (int i = 0; i < 4; i++) begin mSt[i] = 0; mTag[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "cpuReady in reset", {31'd0, cpuReady}, 32'd0);
    check("R1", "busReq in reset", {31'd0, busReq}, 32'd0);
    rstN = 1'b1;
    // R1: every address misses after reset
    for (int a = 0; a < 256; a++) begin
      snoop(2'b01, AW'(a), sh, fl);
      check("R1", "snoop after reset", {30'd0, sh, fl}, 32'd0);
    end
    // directed: E then write (R3), shared read then upgrade (R4), dirty eviction (R8)
    modelCpu(1'b0, 8'h04, 1'b0);
    modelCpu(1'b1, 8'h04, 1'b0);
    modelSnoop(2'b01, 8'h04);
    modelSnoop(2'b10, 8'h04);
    modelCpu(1'b0, 8'h05, 1'b1);
    modelCpu(1'b1, 8'h05, 1'b0);
    modelCpu(1'b0, 8'h09, 1'b0);
    modelSnoop(2'b00, 8'h09);
    modelSnoop(2'b11, 8'h09);
    modelSnoop(2'b10, 8'h0D);
    // pseudo-random mix over every line and three colliding tags
    for (int n = 0; n < 700; n++) begin
      logic [5:0] tg;
      logic [AW-1:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[5:4])
        2'd0: tg = 6'h00;
        2'd1: tg = 6'h01;
        default: tg = 6'h2A;
      endcase
      a = {tg, lf[7:6]};
      case (lf[2:0])
        3'd0, 3'd1, 3'd2: modelCpu(1'b0, a, lf[8]);
        3'd3, 3'd4:       modelCpu(1'b1, a, lf[8]);
        3'd5:             modelSnoop(2'b01, a);
        3'd6:             modelSnoop(2'b10, a);
        default:          modelSnoop(lf[9] ? 2'b01 : 2'b00, a);
      endcase
    end
    summary();
    $finish;
  end

endmodule